// File: doc/BRIEF.md
# Pipelined Parallel-Prefix Carry Network

This block turns per-chunk carry behaviour into the actual carry entering every chunk of a wide, chunked adder. Each of the N positions supplies a generate bit (the chunk produces a carry-out with no carry-in) and a propagate bit (the chunk produces a carry-out when a carry comes in). The network combines them with a logarithmic-depth parallel prefix tree, doubling the combining distance at every stage. Output bit i is the group generate over positions 0..i, which is the carry into the chunk just above position i.

The input vectors are always captured in a register. A register bank can be placed after every second combining stage, and an optional register can hold the final carry vector. A valid flag travels alongside the data with exactly the same delay. A new vector may be presented on every clock. Results leave in order with no gaps. Only the valid flag is reset; the data registers are left free of reset.

Top module: `ks_carry_prefix`

## Requirements
- R1: For every accepted vector, carry_out[i] equals c(i), where c(-1)=0 and c(i) = gen_in[i] | (prop_in[i] & c(i-1)), for all i in 0..N-1.
- R2: The result of a vector accepted on a clock edge (in_valid high) appears with out_valid high exactly LAT edges later. LAT = 1 + (PIPE_EVERY_2 ? floor(S/2) : 0) + PIPE, with S = clog2(N) combining stages. Examples: N=127 with both options on gives LAT=5; N=8 with PIPE=0 and PIPE_EVERY_2=1 gives LAT=2.
- R3: Vectors presented on consecutive cycles produce results on consecutive cycles, in the order they were accepted.
- R4: The cycle after rst is sampled high, out_valid is low. It stays low until a vector accepted after reset reaches the output. Vectors in flight when reset is applied are discarded.
- R5: carry_out[0] equals gen_in[0] of the same vector, whatever prop_in[0] is.
- R6: A generate at position 0 with every higher position propagating sets every carry bit. A single position k with both generate and propagate low clears carry bits k and above, unless a higher position generates.
- R7: While in_valid is low, nothing is emitted, whatever values gen_in and prop_in carry. The number of results equals the number of accepted vectors.
- R8: With PIPE=0, the final carry vector is driven combinationally from the last combining stage, which removes one cycle of latency compared with PIPE=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the valid path, active high |
| in_valid | input | 1 | Marks gen_in/prop_in as a vector to process |
| gen_in | input | N | Per-position generate bits |
| prop_in | input | N | Per-position propagate bits |
| carry_out | output | N | Bit i: carry into the chunk above position i |
| out_valid | output | 1 | carry_out holds a result |

## Verification
Accepting a new vector and emitting the result of an earlier one fall in the same cycle whenever vectors stream in back to back. The bench provokes this with long unbroken bursts, and with bursts broken by idle cycles that carry junk data. Every result is judged against a queue entry stamped with its issue cycle, so both the latency and the order are checked along with the carries. A second instance with the output register removed and fewer stages runs on the same stimulus. Reset is also applied while vectors are still in flight, to show that those results are discarded.

// File: rtl/ks_prefix_pkg.sv
package ks_prefix_pkg;

  function automatic int ks_num_stages(input int n);
    return (n > 1) ? $clog2(n) : 0;
  endfunction

  function automatic int ks_mid_regs(input int stages, input int every2);
    return (every2 != 0) ? (stages / 2) : 0;
  endfunction

  function automatic int ks_latency(input int n, input int pipe, input int every2);
    return 1 + ks_mid_regs(ks_num_stages(n), every2) + ((pipe != 0) ? 1 : 0);
  endfunction

  // bank after stage k (stage 0 is the first combining stage)
  function automatic bit ks_reg_after(input int k, input int every2);
    return (every2 != 0) && ((k % 2) == 1);
  endfunction

  function automatic logic ks_group_g(input logic g_hi, input logic p_hi, input logic g_lo);
    return g_hi | (p_hi & g_lo);
  endfunction

  function automatic logic ks_group_p(input logic p_hi, input logic p_lo);
    return p_hi & p_lo;
  endfunction

endpackage

// File: rtl/ks_pipe_bank.sv
module ks_pipe_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  input  logic         v_in,
  output logic [W-1:0] d_out,
  output logic         v_out
);

  // data path carries no reset so it stays free to move
  always_ff @(posedge clk) begin
    d_out <= d_in;
  end

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
  end

endmodule

// File: rtl/ks_combine_stage.sv
module ks_combine_stage
  import ks_prefix_pkg::*;
#(
  parameter int N    = 8,
  parameter int SPAN = 1
) (
  input  logic [N-1:0] g_in,
  input  logic [N-1:0] p_in,
  output logic [N-1:0] g_out,
  output logic [N-1:0] p_out
);

  for (genvar i = 0; i < N; i++) begin : g_pos
    if (i < SPAN) begin : g_pass
      assign g_out[i] = g_in[i];
      assign p_out[i] = p_in[i];
    end else begin : g_comb
      assign g_out[i] = ks_group_g(g_in[i], p_in[i], g_in[i-SPAN]);
      assign p_out[i] = ks_group_p(p_in[i], p_in[i-SPAN]);
    end
  end

endmodule

// File: rtl/ks_carry_prefix.sv
module ks_carry_prefix
  import ks_prefix_pkg::*;
#(
  parameter int N            = 127,
  parameter int PIPE         = 1,
  parameter int PIPE_EVERY_2 = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [N-1:0] gen_in,
  input  logic [N-1:0] prop_in,
  output logic [N-1:0] carry_out,
  output logic         out_valid
);

  localparam int STAGES = ks_num_stages(N);
  localparam int LAT    = ks_latency(N, PIPE, PIPE_EVERY_2);
  localparam int CW     = $clog2(LAT + 2);

  logic [N-1:0] g_s [STAGES+1];
  logic [N-1:0] p_s [STAGES+1];
  logic         v_s [STAGES+1];

  // entry bank, always present
  logic [2*N-1:0] entry_q;
  ks_pipe_bank #(.W(2*N)) u_entry (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({prop_in, gen_in}),
    .v_in  (in_valid),
    .d_out (entry_q),
    .v_out (v_s[0])
  );
  assign g_s[0] = entry_q[N-1:0];
  assign p_s[0] = entry_q[2*N-1:N];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [N-1:0] gc;
    logic [N-1:0] pc;

    ks_combine_stage #(.N(N), .SPAN(1 << k)) u_comb (
      .g_in  (g_s[k]),
      .p_in  (p_s[k]),
      .g_out (gc),
      .p_out (pc)
    );

    if (ks_reg_after(k, PIPE_EVERY_2)) begin : g_banked
      logic [2*N-1:0] q;
      ks_pipe_bank #(.W(2*N)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({pc, gc}),
        .v_in  (v_s[k]),
        .d_out (q),
        .v_out (v_s[k+1])
      );
      assign g_s[k+1] = q[N-1:0];
      assign p_s[k+1] = q[2*N-1:N];
    end else begin : g_through
      assign g_s[k+1] = gc;
      assign p_s[k+1] = pc;
      assign v_s[k+1] = v_s[k];
    end
  end

  // named tail of the tree, watched by the assertions
  logic [N-1:0] tail_g;
  logic [N-1:0] tail_p;
  logic         tail_valid;
  assign tail_g     = g_s[STAGES];
  assign tail_p     = p_s[STAGES];
  assign tail_valid = v_s[STAGES];

  if (PIPE != 0) begin : g_out_reg
    ks_pipe_bank #(.W(N)) u_out (
      .clk   (clk),
      .rst   (rst),
      .d_in  (tail_g),
      .v_in  (tail_valid),
      .d_out (carry_out),
      .v_out (out_valid)
    );
  end else begin : g_out_comb
    assign carry_out = tail_g;
    assign out_valid = tail_valid;
  end

  // ---------------- assertions ----------------
  logic accept_ev;
  logic emit_ev;
  assign accept_ev = in_valid;
  assign emit_ev   = out_valid;

  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(accept_ev) - CW'(emit_ev);
  end

  a_r2_inflight_bound: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LAT));

  a_r7_no_orphan_output: assert property (@(posedge clk) disable iff (rst)
    emit_ev |-> (inflight != '0));

  a_r4_reset_quiet: assert property (@(posedge clk)
    rst |=> !out_valid);

  // all-propagate span from 0 carries position 0's generate upward
  a_r1_chain_carries: assert property (@(posedge clk) disable iff (rst)
    tail_valid |-> ((tail_p & {N{tail_g[0]}} & ~tail_g) == '0));

  if (N >= 2) begin : g_nest_chk
    a_r1_prop_nested: assert property (@(posedge clk) disable iff (rst)
      tail_valid |-> ((tail_p[N-1:1] & ~tail_p[N-2:0]) == '0));
  end

endmodule

// File: tb/tb_ks_carry_prefix.sv
module tb_ks_carry_prefix;

  localparam int NA = 127;
  localparam int NB = 8;

  function automatic int bench_lat(input int n, input int pipe, input int every2);
    int st;
    st = (n > 1) ? $clog2(n) : 0;
    return 1 + ((every2 != 0) ? st / 2 : 0) + pipe;
  endfunction

  localparam int LAT_A = bench_lat(NA, 1, 1);
  localparam int LAT_B = bench_lat(NB, 0, 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld = 1'b0;
  logic [NA-1:0] g = '0;
  logic [NA-1:0] p = '0;
  logic [NA-1:0] c_a;
  logic          v_a;
  logic [NB-1:0] c_b;
  logic          v_b;

  always #10 clk = ~clk;

  ks_carry_prefix #(.N(NA), .PIPE(1), .PIPE_EVERY_2(1)) dut (
    .clk(clk), .rst(rst), .in_valid(vld), .gen_in(g), .prop_in(p),
    .carry_out(c_a), .out_valid(v_a)
  );

  ks_carry_prefix #(.N(NB), .PIPE(0), .PIPE_EVERY_2(1)) dut_b (
    .clk(clk), .rst(rst), .in_valid(vld), .gen_in(g[NB-1:0]), .prop_in(p[NB-1:0]),
    .carry_out(c_b), .out_valid(v_b)
  );

  typedef struct {
    logic [NA-1:0] c;
    int            issue;
    string         req;
  } exp_t;

  exp_t qa[$];
  exp_t qb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [NA-1:0] ripple(input logic [NA-1:0] gv, input logic [NA-1:0] pv, input int n);
    logic [NA-1:0] r;
    logic c;
    r = '0;
    c = 1'b0;
    for (int i = 0; i < n; i++) begin
      c = gv[i] | (pv[i] & c);
      r[i] = c;
    end
    return r;
  endfunction

  function automatic logic [NA-1:0] rnd();
    logic [127:0] t;
    t = {$urandom(), $urandom(), $urandom(), $urandom()};
    return t[NA-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NA-1:0] act, input logic [NA-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic send(input logic [NA-1:0] gv, input logic [NA-1:0] pv, input string req);
    exp_t ea;
    exp_t eb;
    @(negedge clk);
    g = gv;
    p = pv;
    vld = 1'b1;
    ea.c = ripple(gv, pv, NA);
    ea.issue = cyc;
    ea.req = req;
    eb.c = ripple(gv, pv, NB);
    eb.issue = cyc;
    eb.req = req;
    qa.push_back(ea);
    qb.push_back(eb);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0;
      g = rnd();  // junk while invalid (R7)
      p = rnd();
    end
  endtask

  // monitor / scoreboard
  int last_iss_a = -10;
  int last_out_a = -10;
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (v_a) begin
        if (qa.size() == 0) begin
          check(1'b0, "R7", "dut emitted with nothing pending", c_a, '0);
        end else begin
          exp_t e;
          e = qa.pop_front();
          check(c_a == e.c, e.req, "dut carries", c_a, e.c);
          check(cyc - e.issue == LAT_A, "R2", "dut latency", NA'(cyc - e.issue), NA'(LAT_A));
          if (e.issue == last_iss_a + 1)
            check(cyc == last_out_a + 1, "R3", "dut back-to-back spacing",
                  NA'(cyc - last_out_a), NA'(1));
          last_iss_a = e.issue;
          last_out_a = cyc;
        end
      end
      if (v_b) begin
        if (qb.size() == 0) begin
          check(1'b0, "R7", "dut_b emitted with nothing pending", NA'(c_b), '0);
        end else begin
          exp_t e;
          e = qb.pop_front();
          check(NA'(c_b) == e.c, e.req, "dut_b carries", NA'(c_b), e.c);
          check(cyc - e.issue == LAT_B, "R8", "dut_b latency (PIPE=0)",
                NA'(cyc - e.issue), NA'(LAT_B));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [NA-1:0] pv;
    logic [NA-1:0] gv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #5;
    check(!v_a && !v_b, "R4", "out_valid after reset", NA'({v_a, v_b}), '0);

    // R5: position 0 follows its own generate only
    send(NA'(1), '0, "R5");
    send('0, '1, "R5");
    send(NA'(1), ~NA'(1), "R5");
    idle(2);

    // R6: full-length chain and a kill in the middle
    send(NA'(1), '1, "R6");
    pv = '1; pv[60] = 1'b0;
    send(NA'(1), pv, "R6");
    pv = '1; pv[5] = 1'b0;
    gv = '0; gv[0] = 1'b1; gv[90] = 1'b1;
    send(gv, pv, "R6");
    idle(3);

    // R1/R3: unbroken bursts, sparse and dense generates
    for (int i = 0; i < 40; i++) send(rnd() & rnd() & rnd(), rnd() | rnd(), "R1");
    for (int i = 0; i < 40; i++) send(rnd(), rnd(), "R1");
    idle(2);

    // R7: scattered vectors with junk between them
    for (int i = 0; i < 20; i++) begin
      send(rnd() & rnd(), rnd() | rnd(), "R1");
      idle(1 + (i % 3));
    end
    idle(LAT_A + 3);

    // R4: reset with vectors in flight
    for (int i = 0; i < 3; i++) send(rnd(), rnd(), "R1");
    @(negedge clk);
    vld = 1'b0;
    rst = 1'b1;
    qa.delete();
    qb.delete();
    @(posedge clk);
    #5;
    check(!v_a && !v_b, "R4", "out_valid cycle after reset", NA'({v_a, v_b}), '0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < LAT_A + 2; i++) begin
      @(posedge clk);
      #5;
      check(!v_a && !v_b, "R4", "no ghost after reset", NA'({v_a, v_b}), '0);
    end

    for (int i = 0; i < 10; i++) send(rnd(), rnd() | rnd(), "R1");
    idle(LAT_A + 4);
    check(qa.size() == 0, "R7", "dut results delivered", NA'(qa.size()), '0);
    check(qb.size() == 0, "R7", "dut_b results delivered", NA'(qb.size()), '0);
    summary();
    $finish;
  end

endmodule